// File: doc/BRIEF.md
# Multiply-Accumulate Transfer Peripheral

This block is a 32-by-32 unsigned multiplier with a 64-bit accumulator. It sits beside a processor core and is reached through a window of three transfer registers, index 25 to 27. The core writes into the window and reads from it with byte-lane transfer commands. Each command gives a start register, a start byte inside that register and a length in bytes. The two operands come from processor registers 28 and 29, which are wired into the block continuously.

A single mode bit picks one of two behaviours:
- Multiply-only mode takes a new operand pair and produces a new 64-bit product on every clock. The accumulator is held at zero.
- Accumulate mode takes the operands only when a transfer-out starts at the mode register. It adds their product to the accumulator and copies the sum into the product words.

An accumulation that wraps sets a sticky carry bit. Writing a one to that bit clears it and also zeroes the accumulator.

Top module: `mac_xfer_unit`

## Requirements
- R1: In multiply-only mode (mode bit 0), `prod_o` equals the unsigned 64-bit product of the `op_a` and `op_b` values sampled at the previous clock edge, on every cycle.
- R2: In multiply-only mode the accumulator `acc_o` is zero.
- R3: In accumulate mode the accumulator changes only on a mode-register write. A mode-register write is a valid transfer-out that starts at index 25 with a length of at least 1. On that write, sum = accumulator + op_a*op_b, wrapping modulo 2^64. The sum is stored into both the accumulator and the product words.
- R4: Byte 0 of index 25 is the mode register. Bit 0 is the mode (1 = accumulate) and bit 1 is the carry; the other bits read 0. The mode bit is updated only when byte 0 of index 25 is among the bytes written. The new mode already governs the cycle of that write.
- R5: When an accumulation wraps (new sum less than the value it was added to), the carry bit is set. It stays set until it is cleared as described in R6.
- R6: Suppose a transfer-out writes a 1 into bit 1 of the mode register while the carry is set. The carry is then cleared, and the accumulator is zeroed before that write's own accumulation is applied. Writing 0 to bit 1 leaves the carry unchanged.
- R7: A command is legal only if it starts at index 25, 26 or 27 and the start byte offset plus the length is at most 12. Here the start byte offset is (index-25)*4 + byte. An illegal command raises `x_err` for one cycle after the command and changes no state. It also produces no read data.
- R8: A legal transfer-in raises `rd_valid` for one cycle after the command. `rd_data` then holds the current window image at the bytes the command selects and zero elsewhere. The window image has byte k at `rd_data[8k+7:8k]`: bits 31:0 are index 25, bits 63:32 are the product low word (index 26) and bits 95:64 are the product high word (index 27).
- R9: In accumulate mode, a legal transfer-out that starts at index 26 or 27 replaces the selected product bytes with the same bytes of `x_wdata` and leaves the accumulator unchanged. `x_wdata` uses the same byte layout as `rd_data`.
- R10: Reset clears the product, the accumulator, the mode bit, the carry bit, `x_err`, `rd_valid` and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 32 | First operand (processor register 28) |
| op_b | input | 32 | Second operand (processor register 29) |
| x_valid | input | 1 | A transfer command is present this cycle |
| x_out | input | 1 | 1 = transfer-out (write into window), 0 = transfer-in (read) |
| x_reg | input | 5 | Start register index |
| x_byte | input | 2 | Start byte inside the start register |
| x_len | input | 4 | Length in bytes, 0 to 12 |
| x_wdata | input | 96 | Write data in window byte layout |
| rd_valid | output | 1 | Read data valid, one cycle after a legal transfer-in |
| rd_data | output | 96 | Read data in window byte layout, unselected bytes zero |
| x_err | output | 1 | One-cycle pulse after an illegal command |
| prod_o | output | 64 | Product words (high word at bits 63:32) |
| acc_o | output | 64 | Accumulator |
| acc_mode_o | output | 1 | Current mode bit |
| carry_o | output | 1 | Sticky carry bit |

## Verification
The hardest state to reach is a wrapped accumulation followed by a single mode write that both clears the carry and accumulates into the freshly zeroed accumulator. Random operands almost never make the sum large enough to wrap. The directed part therefore repeats all-ones operands until the carry sets, then clears it in the same write that accumulates a known product. The random part mixes all-ones operands and mode-register writes with a raised bias, so that carry, clear and mode changes keep recurring amid legal and illegal transfers.

// File: rtl/mac_xfer_pkg.sv
package mac_xfer_pkg;
    localparam int unsigned DW        = 32;
    localparam int unsigned PW        = 2 * DW;
    localparam int unsigned WIN_BASE  = 25;
    localparam int unsigned WIN_REGS  = 3;
    localparam int unsigned BPR       = DW / 8;
    localparam int unsigned WIN_BYTES = WIN_REGS * BPR;
    localparam int unsigned WIN_W     = WIN_BYTES * 8;
    localparam int unsigned RW        = 5;
    localparam int unsigned BW        = $clog2(BPR);
    localparam int unsigned LW        = $clog2(WIN_BYTES + 1);
    localparam int unsigned MODE_BIT  = 0;
    localparam int unsigned CARRY_BIT = 1;

    typedef struct packed {
        logic             mode;
        logic             carry;
        logic [PW-1:0]    prod;
        logic [PW-1:0]    acc;
        logic             rd_valid;
        logic [WIN_W-1:0] rd_data;
        logic             err;
    } mac_state_t;
endpackage

// File: rtl/mac_win_decode.sv
module mac_win_decode
    import mac_xfer_pkg::*;
(
    input  logic [RW-1:0]        x_reg,
    input  logic [BW-1:0]        x_byte,
    input  logic [LW-1:0]        x_len,
    output logic                 legal,
    output logic                 at_mode,
    output logic [WIN_BYTES-1:0] lane
);
    localparam int unsigned AW = 8;

    logic [AW-1:0] reg_w;
    logic [AW-1:0] start_w;
    logic [AW-1:0] end_w;
    logic          in_win;

    always_comb begin
        reg_w   = AW'(x_reg);
        start_w = AW'((reg_w - AW'(WIN_BASE)) * AW'(BPR)) + AW'(x_byte);
        end_w   = start_w + AW'(x_len);
        in_win  = (reg_w >= AW'(WIN_BASE)) && (reg_w < AW'(WIN_BASE + WIN_REGS));
        legal   = in_win && (end_w <= AW'(WIN_BYTES));
        at_mode = (reg_w == AW'(WIN_BASE)) && (x_len != '0);
    end

    for (genvar i = 0; i < WIN_BYTES; i++) begin : g_lane
        assign lane[i] = legal && (AW'(i) >= start_w) && (AW'(i) < end_w);
    end
endmodule

// File: rtl/mac_mult.sv
module mac_mult
    import mac_xfer_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [PW-1:0] p
);
    assign p = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
endmodule

// File: rtl/mac_xfer_unit.sv
module mac_xfer_unit
    import mac_xfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    op_a,
    input  logic [DW-1:0]    op_b,
    input  logic             x_valid,
    input  logic             x_out,
    input  logic [RW-1:0]    x_reg,
    input  logic [BW-1:0]    x_byte,
    input  logic [LW-1:0]    x_len,
    input  logic [WIN_W-1:0] x_wdata,
    output logic             rd_valid,
    output logic [WIN_W-1:0] rd_data,
    output logic             x_err,
    output logic [PW-1:0]    prod_o,
    output logic [PW-1:0]    acc_o,
    output logic             acc_mode_o,
    output logic             carry_o
);
    logic                 cmd_legal;
    logic                 cmd_at_mode;
    logic [WIN_BYTES-1:0] cmd_lane;
    logic [PW-1:0]        mul_p;

    mac_win_decode u_dec (
        .x_reg   (x_reg),
        .x_byte  (x_byte),
        .x_len   (x_len),
        .legal   (cmd_legal),
        .at_mode (cmd_at_mode),
        .lane    (cmd_lane)
    );

    mac_mult u_mul (
        .a (op_a),
        .b (op_b),
        .p (mul_p)
    );

    mac_state_t s_q, s_d;

    logic             wr, rd, mode_wr, mode_byte, mode_new, clr;
    logic [PW-1:0]    base, sum, pmerge;
    logic [WIN_W-1:0] img;

    always_comb begin
        s_d       = s_q;
        wr        = x_valid && x_out && cmd_legal;
        rd        = x_valid && !x_out && cmd_legal;
        mode_wr   = wr && cmd_at_mode;
        mode_byte = wr && cmd_lane[0];
        mode_new  = mode_byte ? x_wdata[MODE_BIT] : s_q.mode;
        clr       = mode_byte && x_wdata[CARRY_BIT] && s_q.carry;
        base      = clr ? '0 : s_q.acc;
        sum       = base + mul_p;

        img = {s_q.prod, {(DW-2){1'b0}}, s_q.carry, s_q.mode};
        for (int k = 0; k < WIN_BYTES; k++) begin
            s_d.rd_data[k*8 +: 8] = (rd && cmd_lane[k]) ? img[k*8 +: 8] : 8'h00;
        end
        s_d.rd_valid = rd;
        s_d.err      = x_valid && !cmd_legal;

        pmerge = s_q.prod;
        for (int k = BPR; k < WIN_BYTES; k++) begin
            if (wr && cmd_lane[k]) begin
                pmerge[(k-BPR)*8 +: 8] = x_wdata[k*8 +: 8];
            end
        end

        s_d.mode  = mode_new;
        s_d.carry = s_q.carry && !clr;
        if (!mode_new) begin
            s_d.prod = mul_p;
            s_d.acc  = '0;
        end else if (mode_wr) begin
            s_d.prod  = sum;
            s_d.acc   = sum;
            s_d.carry = (s_q.carry && !clr) || (sum < base);
        end else begin
            s_d.prod = pmerge;
            s_d.acc  = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid   = s_q.rd_valid;
    assign rd_data    = s_q.rd_data;
    assign x_err      = s_q.err;
    assign prod_o     = s_q.prod;
    assign acc_o      = s_q.acc;
    assign acc_mode_o = s_q.mode;
    assign carry_o    = s_q.carry;
endmodule

// File: rtl/mac_xfer_chk.sv
module mac_xfer_chk
    import mac_xfer_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [DW-1:0]    op_a,
    input logic [DW-1:0]    op_b,
    input logic             x_valid,
    input logic             x_out,
    input logic [RW-1:0]    x_reg,
    input logic [BW-1:0]    x_byte,
    input logic [LW-1:0]    x_len,
    input logic [WIN_W-1:0] x_wdata,
    input logic             rd_valid,
    input logic [WIN_W-1:0] rd_data,
    input logic             x_err,
    input logic [PW-1:0]    prod_o,
    input logic [PW-1:0]    acc_o,
    input logic             acc_mode_o,
    input logic             carry_o
);
    logic seen_q;
    logic bad_cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    always_comb begin
        bad_cmd = x_valid && ((int'(x_reg) < int'(WIN_BASE)) ||
                  (int'(x_reg) * int'(BPR) + int'(x_byte) + int'(x_len) >
                   int'((WIN_BASE + WIN_REGS) * BPR)));
    end

    AST_MUL_TRACKS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !acc_mode_o) |-> (prod_o == ({{DW{1'b0}}, $past(op_a)} * {{DW{1'b0}}, $past(op_b)}))); // R1

    AST_MUL_ACC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_mode_o |-> (acc_o == '0)); // R2

    AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode_o && !x_valid) |=> ($stable(acc_o) && acc_mode_o)); // R3

    AST_CARRY_RISE_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry_o) |-> acc_mode_o); // R5

    AST_BAD_CMD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |=> (x_err && !rd_valid)); // R7

    AST_BAD_CMD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_cmd && acc_mode_o) |=> ($stable(prod_o) && $stable(acc_o) && $stable(carry_o) && acc_mode_o)); // R7

    AST_RD_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, x_err})); // R8

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0)); // R8
endmodule

bind mac_xfer_unit mac_xfer_chk i_chk (.*);

// File: tb/test_mac_xfer_unit.sv
`timescale 1ns/1ps
module test_mac_xfer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        x_valid = 1'b0, x_out = 1'b0;
    logic [4:0]  x_reg = '0;
    logic [1:0]  x_byte = '0;
    logic [3:0]  x_len = '0;
    logic [95:0] x_wdata = '0;
    logic        rd_valid, x_err, acc_mode_o, carry_o;
    logic [95:0] rd_data;
    logic [63:0] prod_o, acc_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [63:0] m_prod = '0, m_acc = '0;
    logic        m_mode = 1'b0, m_carry = 1'b0;
    logic        e_err = 1'b0, e_rdv = 1'b0;
    logic [95:0] e_rdd = '0;

    always #4 clk = ~clk;

    mac_xfer_unit i_mac_xfer_unit (.*);

    task automatic chk(input string tag, input string what, input logic [95:0] act, input logic [95:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "prod", 96'(prod_o), 96'(m_prod));
        chk(tag, "acc", 96'(acc_o), 96'(m_acc));
        chk(tag, "mode", 96'(acc_mode_o), 96'(m_mode));
        chk(tag, "carry", 96'(carry_o), 96'(m_carry));
        chk(tag, "err", 96'(x_err), 96'(e_err));
        chk(tag, "rd_valid", 96'(rd_valid), 96'(e_rdv));
        chk(tag, "rd_data", rd_data, e_rdd);
    endtask

    function automatic logic [95:0] image();
        return {m_prod, 30'b0, m_carry, m_mode};
    endfunction

    task automatic cyc(input logic v, input logic o, input logic [4:0] r, input logic [1:0] b,
                       input logic [3:0] l, input logic [95:0] wd, input logic [31:0] a,
                       input logic [31:0] bb, input string tag);
        int st;
        logic okr, wr, rd, mw, b0, nm, clr;
        logic [11:0] sel;
        logic [63:0] p, base, sum, pm;
        logic [95:0] img;
        st  = (int'(r) - 25) * 4 + int'(b);
        okr = (r >= 25) && (r <= 27) && (st + int'(l) <= 12);
        for (int k = 0; k < 12; k++) sel[k] = okr && (k >= st) && (k < st + int'(l));
        wr  = v && o && okr;
        rd  = v && !o && okr;
        mw  = wr && (r == 25) && (l != 0);
        b0  = wr && sel[0];
        nm  = b0 ? wd[0] : m_mode;
        clr = b0 && wd[1] && m_carry;
        p   = 64'(a) * 64'(bb);
        base = clr ? 64'd0 : m_acc;
        img = image();
        e_rdd = '0;
        for (int k = 0; k < 12; k++) if (rd && sel[k]) e_rdd[k*8 +: 8] = img[k*8 +: 8];
        e_rdv = rd;
        e_err = v && !okr;
        pm = m_prod;
        for (int k = 4; k < 12; k++) if (wr && sel[k]) pm[(k-4)*8 +: 8] = wd[k*8 +: 8];
        m_carry = m_carry && !clr;
        if (!nm) begin
            m_prod = p; m_acc = '0;
        end else if (mw) begin
            sum = base + p;
            m_prod = sum; m_acc = sum;
            if (sum < base) m_carry = 1'b1;
        end else begin
            m_prod = pm; m_acc = base;
        end
        m_mode = nm;
        x_valid = v; x_out = o; x_reg = r; x_byte = b; x_len = l; x_wdata = wd;
        op_a = a; op_b = bb;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] ra, rb;
        logic [4:0]  rr;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check_all("R10_reset");
        rst_n = 1'b1;
        @(negedge clk);
        // multiply-only mode
        cyc(0, 0, 0, 0, 0, '0, 32'd3, 32'd5, "R1_small");
        cyc(0, 0, 0, 0, 0, '0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1_max");
        cyc(0, 0, 0, 0, 0, '0, 32'h8000_0000, 32'd2, "R2_mul_acc");
        cyc(1, 0, 26, 0, 8, '0, 32'h1234_5678, 32'h9ABC_DEF0, "R8_read_prod");
        cyc(1, 0, 25, 0, 12, '0, 32'd7, 32'd9, "R8_read_all");
        // range errors
        cyc(1, 1, 24, 3, 1, '1, 32'd1, 32'd1, "R7_below");
        cyc(1, 0, 27, 2, 3, '0, 32'd1, 32'd1, "R7_overrun");
        cyc(1, 1, 28, 0, 0, '1, 32'd1, 32'd1, "R7_above");
        cyc(1, 0, 27, 3, 1, '0, 32'd2, 32'd2, "R7_last_byte_ok");
        // enter accumulate mode: accumulates at once
        cyc(1, 1, 25, 0, 1, 96'h1, 32'd10, 32'd20, "R4_enter_acc");
        cyc(0, 0, 0, 0, 0, '0, 32'd99, 32'd99, "R3_hold");
        cyc(1, 1, 25, 1, 1, 96'h0, 32'd3, 32'd4, "R3_acc_byte1");
        cyc(1, 1, 26, 0, 2, 96'hAB_CD00_0000_0000, 32'd1, 32'd1, "R9_prod_write");
        cyc(1, 1, 24, 0, 2, '1, 32'd1, 32'd1, "R7_ignored_acc");
        // drive the accumulator to wrap
        cyc(1, 1, 25, 0, 1, 96'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5_acc1");
        cyc(1, 1, 25, 0, 1, 96'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5_wrap");
        cyc(1, 1, 25, 0, 1, 96'h1, 32'd1, 32'd1, "R5_sticky");
        cyc(1, 0, 25, 0, 1, '0, 32'd1, 32'd1, "R8_read_carry");
        cyc(1, 1, 25, 0, 1, 96'h3, 32'd6, 32'd7, "R6_clear");
        cyc(1, 1, 25, 0, 1, 96'h0, 32'd6, 32'd7, "R4_exit_acc");
        cyc(0, 0, 0, 0, 0, '0, 32'd11, 32'd13, "R2_back_mul");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            ra = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            rb = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            rr = ($urandom % 2 == 0) ? 5'd25 : 5'(24 + $urandom % 5);
            cyc(($urandom % 3) != 0, ($urandom % 3) != 0, rr, 2'($urandom), 4'($urandom % 13),
                {$urandom, $urandom, 30'($urandom), 1'($urandom), 1'($urandom % 4 != 0)},
                ra, rb, "R3_random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule